// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

A synchronous single-port SRAM model with 18-bit words: 16 data bits and 2 parity bits split into two byte lanes. Reads and writes may be freely mixed on consecutive clocks without idle cycles. Read data leaves through a registered output stage one clock after the address edge. Write data follows its address by two clocks, so the bus slot that a write occupies lines up with the slot a read would have used. Because of this, a read can follow a write, or a write can follow a read, with no dead cycle.

The shared data bus is modelled as separate `dq_i`, `dq_o` and `dq_oe_o` ports. Output drive is allowed only in the cycle that carries read data, and then only while the asynchronous output enable is low. Drive is removed automatically while write data is expected and after a deselect. A clock-enable input freezes the whole pipeline. Three chip enables select the device. Byte-select inputs mask writes per lane. A read of the address written on the previous accepted edge returns the new data, merged by lane.

Top module: `zt_sram`

## Requirements
- R1: An access is accepted only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0 on the same enabled edge. Otherwise no read drives the bus and no word is written.
- R2: An access also needs `cen_ni`=0 and `adv_ld_i`=0. An edge with `adv_ld_i`=1 starts no access: there is no drive and no write.
- R3: A read accepted at edge N (`we_ni`=1) places the addressed word on `dq_o` after the next enabled edge N+1. `dq_oe_o` is high in that cycle while `oe_ni`=0.
- R4: A write accepted at edge N (`we_ni`=0) keeps `dq_oe_o` low from edge N+1 to edge N+2, whatever `oe_ni` is. It stores `dq_i` at the enabled edge N+2.
- R5: Byte-select `bws_ni` is sampled with the write address and is active low. Bit 0 gates `dq` bits 7:0 and bit 16. Bit 1 gates bits 15:8 and bit 17. Lanes that are not selected keep their old contents.
- R6: An edge with `cen_ni`=1 is ignored. Pipeline state, memory, `dq_o` and the drive state all hold, and a pending write waits for the next enabled edge.
- R7: A deselect at edge N leaves the drive of an earlier read in place until edge N+1, then drive is off. The first cycle after a read leaves the deselected state is also undriven.
- R8: `oe_ni`=1 forces `dq_oe_o` low at once, without a clock edge. `oe_ni` alone never turns on drive.
- R9: A new access is accepted on every enabled edge. Alternating write, read, write, read returns correct data each slot.
- R10: A read accepted on the edge right after a write to the same address returns the new data, merged by lane with the old word.
- R11: After reset, `dq_oe_o`=0 and `dq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_ld_i | input | 1 | Low loads a new access |
| we_ni | input | 1 | Write enable, active low |
| bws_ni | input | 2 | Byte-lane write selects, active low |
| addr_i | input | AW | Word address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 18 | Bus data into the device |
| dq_o | output | 18 | Registered read data |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The assertions assume that every synchronous input is stable around the rising edge, and that `oe_ni` may change at any time. The bench drives all inputs on the falling edge and samples just after the rising edge, so that assumption holds. The checker builds its own two-stage record of accepted reads and writes from the ports. It assumes the bench supplies write data exactly two enabled edges after each write address, and the bench tasks always place that data in the matching slot, including across stalls.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int DATA_W  = 16;
  localparam int LANES   = 2;
  localparam int LANE_DW = DATA_W / LANES;
  localparam int LANE_W  = LANE_DW + 1;
  localparam int WORD_W  = DATA_W + LANES;

  // lane l owns data bits [l*LANE_DW +: LANE_DW] and parity bit DATA_W+l
  function automatic logic [WORD_W-1:0] lane_bits(input logic [LANES-1:0] sel);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int b = 0; b < LANE_DW; b++) m[l*LANE_DW+b] = sel[l];
      m[DATA_W+l] = sel[l];
    end
    return m;
  endfunction

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [LANES-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] sel_i,
  input  logic [AW-1:0]    addr_i,
  output logic             s1_rd_o,
  output logic             s1_wr_o,
  output logic [AW-1:0]    s1_addr_o,
  output logic             s2_wr_o,
  output logic [LANES-1:0] s2_sel_o,
  output logic [AW-1:0]    s2_addr_o
);
  ctl_t          s1_q, s2_q;
  logic [AW-1:0] a1_q, a2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      a1_q <= '0;
      a2_q <= '0;
    end else if (en_i) begin
      s1_q <= '{vld: acc_i, wr: wr_i, sel: sel_i};
      a1_q <= addr_i;
      s2_q <= s1_q;
      a2_q <= a1_q;
    end
  end

  assign s1_rd_o   = s1_q.vld && !s1_q.wr;
  assign s1_wr_o   = s1_q.vld &&  s1_q.wr;
  assign s1_addr_o = a1_q;
  assign s2_wr_o   = s2_q.vld &&  s2_q.wr;
  assign s2_sel_o  = s2_q.sel;
  assign s2_addr_o = a2_q;
endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array
  import zt_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [LANES-1:0]  wsel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wsel_i[l])
        mem[waddr_i] <= {wdata_i[DATA_W+l], wdata_i[l*LANE_DW +: LANE_DW]};
    end

    assign rd = mem[raddr_i];
    assign rdata_o[l*LANE_DW +: LANE_DW] = rd[LANE_DW-1:0];
    assign rdata_o[DATA_W+l]             = rd[LANE_DW];
  end
endmodule

// File: rtl/zt_rd_path.sv
module zt_rd_path
  import zt_sram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rd_go_i,
  input  logic              fwd_i,
  input  logic [LANES-1:0]  fwd_sel_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [WORD_W-1:0] dq_i,
  input  logic              oe_ni,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [WORD_W-1:0] fmask, rword, dout_q;
  logic              drive_q;

  assign fmask = fwd_i ? lane_bits(fwd_sel_i) : '0;
  assign rword = (mem_rdata_i & ~fmask) | (dq_i & fmask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      drive_q <= 1'b0;
    end else if (en_i) begin
      drive_q <= rd_go_i;
      if (rd_go_i) dout_q <= rword;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = drive_q && !oe_ni;
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              adv_ld_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bws_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              oe_ni,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              en, acc;
  logic              s1_rd, s1_wr, s2_wr;
  logic [AW-1:0]     s1_addr, s2_addr;
  logic [LANES-1:0]  s2_sel;
  logic [WORD_W-1:0] mem_rdata;
  logic              fwd;

  assign en  = !cen_ni;
  assign acc = !ce1_ni && ce2_i && !ce3_ni && !adv_ld_i;

  zt_cmd_pipe #(.AW(AW)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .acc_i     (acc),
    .wr_i      (!we_ni),
    .sel_i     (~bws_ni),
    .addr_i    (addr_i),
    .s1_rd_o   (s1_rd),
    .s1_wr_o   (s1_wr),
    .s1_addr_o (s1_addr),
    .s2_wr_o   (s2_wr),
    .s2_sel_o  (s2_sel),
    .s2_addr_o (s2_addr)
  );

  zt_mem_array #(.AW(AW)) u_mem (
    .clk_i   (clk_i),
    .wr_en_i (en && s2_wr),
    .waddr_i (s2_addr),
    .wsel_i  (s2_sel),
    .wdata_i (dq_i),
    .raddr_i (s1_addr),
    .rdata_o (mem_rdata)
  );

  // write in its data slot while the next read loads: bypass by lane
  assign fwd = s2_wr && !s1_wr && (s1_addr == s2_addr);

  zt_rd_path u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .rd_go_i     (s1_rd),
    .fwd_i       (fwd),
    .fwd_sel_i   (s2_sel),
    .mem_rdata_i (mem_rdata),
    .dq_i        (dq_i),
    .oe_ni       (oe_ni),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o)
  );
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic              adv_ld_i,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [WORD_W-1:0] dq_o,
  input logic              dq_oe_o
);
  logic c1_vld, c1_wr, c2_vld, c2_wr, take;

  assign take = !ce1_ni && ce2_i && !ce3_ni && !adv_ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_vld <= 1'b0; c1_wr <= 1'b0;
      c2_vld <= 1'b0; c2_wr <= 1'b0;
    end else if (!cen_ni) begin
      c1_vld <= take;   c1_wr <= !we_ni;
      c2_vld <= c1_vld; c2_wr <= c1_wr;
    end
  end

  AST_NO_DRIVE_WDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2_vld && c2_wr) |-> !dq_oe_o); // R4

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (c2_vld && !c2_wr)); // R7

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2_vld && !c2_wr && !oe_ni) |-> dq_oe_o); // R3

  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o); // R8

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> $stable(dq_o)); // R6
endmodule

bind zt_sram zt_sram_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cen_ni   (cen_ni),
  .ce1_ni   (ce1_ni),
  .ce2_i    (ce2_i),
  .ce3_ni   (ce3_ni),
  .adv_ld_i (adv_ld_i),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .dq_o     (dq_o),
  .dq_oe_o  (dq_oe_o)
);

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
  localparam int AW = 8;
  localparam logic [17:0] D1  = 18'h2A5A5;
  localparam logic [17:0] D10 = 18'h1C3C3;
  localparam logic [17:0] D11 = 18'h05A5A;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cen_ni = 1'b0, ce1_ni = 1'b1, ce2_i = 1'b1, ce3_ni = 1'b0;
  logic adv_ld_i = 1'b0, we_ni = 1'b1, oe_ni = 1'b0;
  logic [1:0]    bws_ni = 2'b11;
  logic [AW-1:0] addr_i = '0;
  logic [17:0]   dq_i = '0, dq_o;
  logic          dq_oe_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zt_sram #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cen_ni(cen_ni), .ce1_ni(ce1_ni),
    .ce2_i(ce2_i), .ce3_ni(ce3_ni), .adv_ld_i(adv_ld_i), .we_ni(we_ni),
    .bws_ni(bws_ni), .addr_i(addr_i), .oe_ni(oe_ni), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic cyc(input logic cen, input logic c1, input logic c2, input logic c3,
                     input logic adv, input logic we, input logic [1:0] bws,
                     input logic [AW-1:0] a, input logic [17:0] d);
    @(negedge clk);
    cen_ni = cen; ce1_ni = c1; ce2_i = c2; ce3_ni = c3;
    adv_ld_i = adv; we_ni = we; bws_ni = bws; addr_i = a; dq_i = d;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(0, 0, 1, 0, 0, 1, 2'b11, a, '0);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [1:0] bws, input logic [17:0] d);
    cyc(0, 0, 1, 0, 0, 0, bws, a, d);
  endtask
  task automatic nop(input logic [17:0] d);
    cyc(0, 1, 1, 0, 0, 1, 2'b11, '0, d);
  endtask
  task automatic stall(input logic [17:0] d);
    cyc(1, 0, 1, 0, 0, 0, 2'b00, 8'd10, d);
  endtask

  task automatic t_reset;
    chk("R11 oe after reset", dq_oe_o, 0);
    chk("R11 dq after reset", dq_o, 0);
  endtask

  task automatic t_basic;
    wr(5, 2'b00, '0);
    chk("R4 no drive after addr edge", dq_oe_o, 0);
    nop('0);
    chk("R4 write data slot undriven", dq_oe_o, 0);
    nop(D1);
    rd(5);
    nop('0);
    chk("R3 read drive", dq_oe_o, 1);
    chk("R3 read data", dq_o, D1);
  endtask

  task automatic t_b2b;
    wr(10, 2'b00, '0);
    rd(5);
    chk("R4 slot of first write", dq_oe_o, 0);
    wr(11, 2'b00, D10);
    chk("R9 read after write data", dq_o, D1);
    chk("R9 read drive", dq_oe_o, 1);
    rd(10);
    chk("R4 slot of second write", dq_oe_o, 0);
    nop(D11);
    chk("R9 read back 10", dq_o, D10);
    rd(11);
    nop('0);
    chk("R9 read back 11", dq_o, D11);
  endtask

  task automatic t_lanes;
    wr(20, 2'b00, '0); nop('0); nop(18'h3FFFF);
    wr(20, 2'b10, '0); nop('0); nop(18'h00000);
    rd(20); nop('0);
    chk("R5 lane0 only cleared", dq_o, 18'h2FF00);
    wr(20, 2'b01, '0); nop('0); nop(18'h15555);
    rd(20); nop('0);
    chk("R5 lane1 only written", dq_o, 18'h05500);
    wr(20, 2'b11, '0); nop('0); nop(18'h3FFFF);
    rd(20); nop('0);
    chk("R5 no lane selected", dq_o, 18'h05500);
  endtask

  task automatic t_fwd;
    wr(31, 2'b00, '0);
    rd(31);
    nop(18'h0ABCD);
    chk("R10 forward full word", dq_o, 18'h0ABCD);
    wr(31, 2'b01, '0);
    rd(31);
    nop(18'h3FFFF);
    chk("R10 forward lane merge", dq_o, 18'h2FFCD);
  endtask

  task automatic t_stall;
    rd(5); nop('0);
    for (int i = 0; i < 3; i++) begin
      stall(18'h3FFFF);
      chk("R6 dq held in stall", dq_o, D1);
      chk("R6 drive held in stall", dq_oe_o, 1);
    end
    wr(40, 2'b00, '0);
    nop('0);
    stall(18'h11111);
    chk("R6 write slot held undriven", dq_oe_o, 0);
    stall(18'h11111);
    nop(18'h1F0F0);
    rd(40); nop('0);
    chk("R6 delayed capture", dq_o, 18'h1F0F0);
    rd(10); nop('0);
    chk("R6 stalled write ignored", dq_o, D10);
  endtask

  task automatic t_desel;
    rd(5);
    cyc(0, 0, 0, 0, 0, 1, 2'b11, 8'd10, '0);
    chk("R7 drive of earlier read kept", dq_oe_o, 1);
    cyc(0, 0, 1, 1, 0, 1, 2'b11, 8'd10, '0);
    chk("R7 off after deselect", dq_oe_o, 0);
    rd(10);
    chk("R7 first cycle out of deselect", dq_oe_o, 0);
    nop('0);
    chk("R7 read after reselect", dq_o, D10);
    cyc(0, 1, 1, 0, 0, 0, 2'b00, 8'd5, '0); nop('0); nop('0);
    rd(5); nop('0);
    chk("R1 deselected write ignored", dq_o, D1);
  endtask

  task automatic t_adv;
    nop('0);
    cyc(0, 0, 1, 0, 1, 1, 2'b11, 8'd10, '0);
    nop('0);
    chk("R2 adv high no read drive", dq_oe_o, 0);
    cyc(0, 0, 1, 0, 1, 0, 2'b00, 8'd5, '0); nop('0); nop('0);
    rd(5); nop('0);
    chk("R2 adv high no write", dq_o, D1);
  endtask

  task automatic t_oe;
    rd(5); nop('0);
    chk("R8 drive with oe low", dq_oe_o, 1);
    oe_ni = 1'b1; #1;
    chk("R8 oe high removes drive", dq_oe_o, 0);
    oe_ni = 1'b0; #1;
    chk("R8 oe low restores drive", dq_oe_o, 1);
    wr(50, 2'b00, '0); nop('0);
    chk("R8 oe low cannot drive write slot", dq_oe_o, 0);
    nop(18'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_b2b();
    t_lanes();
    t_fwd();
    t_stall();
    t_desel();
    t_adv();
    t_oe();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule